// File: doc/BRIEF.md
# Pointer Data Address Generator

This block forms the data-space address for a load or store. The caller hands it the 16-bit value of one of three pointers, which are built from register pairs. It also hands it an addressing mode, a 6-bit unsigned displacement and a 16-bit direct constant. From these the block produces the effective address. It also produces the pointer value that must be written back, together with the identity of the pointer to write. The register file, the SRAM array and the instruction decoder sit outside the block.

The data map is linear. The lowest 32 addresses select the working registers. The next 64 select the I/O locations, and the block also reports an I/O port number for them. Internal SRAM comes next, and anything above it is flagged as external memory. A separate lookup mode treats the pointer as a byte address into program memory and raises no data-region select.

Requests enter on a valid/ready handshake and results leave on another, through a single register stage. The stage accepts a new request whenever it is empty or its result is being taken in the same cycle. A stalled result stays on the outputs unchanged until it is taken.

Top module: `ptr_addr_gen`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: Mode codes 0, 6 and 7 (plain indirect): the address is the pointer value and `out_wb_en` is 0.
- R3: Mode 1 (post-increment): the address is the pointer value, `out_wb_en` is 1, `out_wb_val` is pointer+1 modulo 2^16, and `out_wb_ptr` repeats `in_ptr_sel`.
- R4: Mode 2 (pre-decrement): the address and `out_wb_val` are both pointer-1 modulo 2^16, `out_wb_en` is 1, and `out_wb_ptr` repeats `in_ptr_sel`.
- R5: Mode 3 (displacement): when `in_ptr_sel` is 1 (Y) or 2 (Z), the address is pointer+q modulo 2^16, with q unsigned from 0 to 63. For any other select code, q is ignored and the address is the pointer. There is no write-back in either case.
- R6: Mode 4 (direct): the address is `in_direct`, the pointer value and select are ignored, and there is no write-back.
- R7: Mode 5 (program lookup): the address is the pointer value, `out_prog` is 1, all four data-region selects are 0, and there is no write-back.
- R8: For every mode except 5, exactly one region select is high. `out_sel_reg` covers addresses 0x0000-0x001F, `out_sel_io` covers 0x0020-0x005F, `out_sel_sram` covers 0x0060-0x015F and `out_sel_ext` covers 0x0160 and above.
- R9: `out_io_port` is the address minus 0x20 while `out_sel_io` is high, and 0 otherwise.
- R10: `in_ready` equals `!out_valid || out_ready`. An accepted request produces exactly one result on the next cycle. While `out_valid` is high and `out_ready` is low, every output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_ptr_sel | input | 2 | Pointer code: 0 X, 1 Y, 2 Z |
| in_mode | input | 3 | Addressing mode code (see R2-R7) |
| in_ptr_val | input | 16 | Current value of the selected pointer |
| in_disp | input | 6 | Unsigned displacement q |
| in_direct | input | 16 | Direct address constant |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 16 | Effective address |
| out_sel_reg | output | 1 | Address in working-register region |
| out_sel_io | output | 1 | Address in I/O region |
| out_sel_sram | output | 1 | Address in internal SRAM |
| out_sel_ext | output | 1 | Address beyond internal SRAM |
| out_prog | output | 1 | Program-memory lookup address |
| out_io_port | output | 6 | I/O port number |
| out_wb_en | output | 1 | Pointer write-back required |
| out_wb_ptr | output | 2 | Pointer code to write back |
| out_wb_val | output | 16 | Updated pointer value |

## Verification
The bench pushes pointers of 0xFFFF into post-increment and 0x0000 into pre-decrement. A design without 16-bit wrap would write back a 17-bit value, or address the wrong place. Direct addresses are placed on both sides of every region edge: 0x1F/0x20, 0x5F/0x60 and 0x15F/0x160. An off-by-one decoder raises two selects there or the wrong one, and an error in the I/O offset shows up in the port number. Displacement is tried with X, and q=63 is added to a pointer near the top of the space, which catches a design that applies q to X or treats q as signed. Random stalls check that a held result neither changes nor repeats, and that no request is lost.

// File: rtl/ptr_addr_gen_pkg.sv
package ptr_addr_gen_pkg;
  typedef enum logic [1:0] {
    PTR_X   = 2'd0,
    PTR_Y   = 2'd1,
    PTR_Z   = 2'd2,
    PTR_RSV = 2'd3
  } ptr_sel_e;

  typedef enum logic [2:0] {
    AM_PLAIN  = 3'd0,
    AM_POSTINC = 3'd1,
    AM_PREDEC = 3'd2,
    AM_DISP   = 3'd3,
    AM_DIRECT = 3'd4,
    AM_LOOKUP = 3'd5,
    AM_RSV6   = 3'd6,
    AM_RSV7   = 3'd7
  } addr_mode_e;

  typedef struct packed {
    logic regs;
    logic io;
    logic sram;
    logic ext;
  } region_t;
endpackage

// File: rtl/dag_ptr_arith.sv
module dag_ptr_arith
  import ptr_addr_gen_pkg::*;
#(
  parameter int AW = 16,
  parameter int QW = 6
) (
  input  logic [1:0]    sel,
  input  logic [2:0]    mode,
  input  logic [AW-1:0] ptr,
  input  logic [QW-1:0] q,
  input  logic [AW-1:0] direct,
  output logic [AW-1:0] ea,
  output logic          wb_en,
  output logic [AW-1:0] wb_val,
  output logic          prog
);
  logic [AW-1:0] ptr_inc, ptr_dec, ptr_disp;
  logic          disp_ok;

  assign ptr_inc  = ptr + AW'(1);
  assign ptr_dec  = ptr - AW'(1);
  assign disp_ok  = (sel == PTR_Y) || (sel == PTR_Z);
  assign ptr_disp = disp_ok ? ptr + AW'(q) : ptr;

  always_comb begin
    ea     = ptr;
    wb_en  = 1'b0;
    wb_val = ptr;
    prog   = 1'b0;
    unique case (addr_mode_e'(mode))
      AM_POSTINC: begin wb_en = 1'b1; wb_val = ptr_inc; end
      AM_PREDEC:  begin ea = ptr_dec; wb_en = 1'b1; wb_val = ptr_dec; end
      AM_DISP:    ea = ptr_disp;
      AM_DIRECT:  ea = direct;
      AM_LOOKUP:  prog = 1'b1;
      default:    ea = ptr;
    endcase
  end
endmodule

// File: rtl/dag_region_decode.sv
module dag_region_decode
  import ptr_addr_gen_pkg::*;
#(
  parameter int AW         = 16,
  parameter int NUM_REGS   = 32,
  parameter int NUM_IO     = 64,
  parameter int SRAM_BYTES = 256
) (
  input  logic                      valid,
  input  logic [AW-1:0]             ea,
  input  logic                      prog,
  output region_t                   region,
  output logic [$clog2(NUM_IO)-1:0] io_port
);
  localparam int IO_W = $clog2(NUM_IO);
  localparam logic [31:0] IO_BASE   = 32'(NUM_REGS);
  localparam logic [31:0] SRAM_BASE = 32'(NUM_REGS + NUM_IO);
  localparam logic [31:0] SRAM_END  = 32'(NUM_REGS + NUM_IO + SRAM_BYTES);
  localparam logic [31:0] SPACE     = 32'(1) << AW;

  logic [31:0] ea32;
  logic        data_acc;
  assign ea32     = 32'(ea);
  assign data_acc = valid && !prog;

  assign region.regs = data_acc && (ea32 < IO_BASE);
  assign region.io   = data_acc && (ea32 >= IO_BASE) && (ea32 < SRAM_BASE);
  assign region.sram = data_acc && (ea32 >= SRAM_BASE) && (ea32 < SRAM_END);

  generate
    if (SRAM_END >= SPACE) begin : g_no_ext
      assign region.ext = 1'b0;
    end else begin : g_ext
      assign region.ext = data_acc && (ea32 >= SRAM_END);
    end
  endgenerate

  assign io_port = region.io ? IO_W'(ea32 - IO_BASE) : '0;
endmodule

// File: rtl/dag_out_stage.sv
module dag_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  // R10: a stalled result keeps its value
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen
  import ptr_addr_gen_pkg::*;
#(
  parameter int AW         = 16,
  parameter int QW         = 6,
  parameter int NUM_REGS   = 32,
  parameter int NUM_IO     = 64,
  parameter int SRAM_BYTES = 256
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [1:0]                in_ptr_sel,
  input  logic [2:0]                in_mode,
  input  logic [AW-1:0]             in_ptr_val,
  input  logic [QW-1:0]             in_disp,
  input  logic [AW-1:0]             in_direct,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [AW-1:0]             out_addr,
  output logic                      out_sel_reg,
  output logic                      out_sel_io,
  output logic                      out_sel_sram,
  output logic                      out_sel_ext,
  output logic                      out_prog,
  output logic [$clog2(NUM_IO)-1:0] out_io_port,
  output logic                      out_wb_en,
  output logic [1:0]                out_wb_ptr,
  output logic [AW-1:0]             out_wb_val
);
  localparam int IO_W  = $clog2(NUM_IO);
  localparam int RES_W = AW + 1 + AW + 2 + 1;

  logic [AW-1:0]    c_ea, c_wb_val;
  logic             c_wb_en, c_prog;
  logic [RES_W-1:0] c_res, r_res;
  region_t          region;

  dag_ptr_arith #(.AW(AW), .QW(QW)) u_arith (
    .sel(in_ptr_sel), .mode(in_mode), .ptr(in_ptr_val), .q(in_disp),
    .direct(in_direct), .ea(c_ea), .wb_en(c_wb_en), .wb_val(c_wb_val),
    .prog(c_prog)
  );

  assign c_res = {c_ea, c_wb_en, c_wb_val, in_ptr_sel, c_prog};

  dag_out_stage #(.W(RES_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(c_res), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(r_res)
  );

  assign {out_addr, out_wb_en, out_wb_val, out_wb_ptr, out_prog} = r_res;

  dag_region_decode #(
    .AW(AW), .NUM_REGS(NUM_REGS), .NUM_IO(NUM_IO), .SRAM_BYTES(SRAM_BYTES)
  ) u_decode (
    .valid(out_valid), .ea(out_addr), .prog(out_prog),
    .region(region), .io_port(out_io_port)
  );

  assign out_sel_reg  = region.regs;
  assign out_sel_io   = region.io;
  assign out_sel_sram = region.sram;
  assign out_sel_ext  = region.ext;

  logic fire;
  assign fire = in_valid && in_ready;

  // R8: one data region per data access
  a_r8_one_region: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_prog |-> $onehot({out_sel_reg, out_sel_io, out_sel_sram, out_sel_ext}));
  // R7: lookup raises no data select
  a_r7_lookup_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_prog |-> !out_sel_reg && !out_sel_io && !out_sel_sram && !out_sel_ext && !out_wb_en);
  // R3: post-increment writes back address+1
  a_r3_postinc: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_mode == AM_POSTINC |=> out_valid && out_wb_en && out_wb_val == out_addr + AW'(1)
      && out_addr == $past(in_ptr_val));
  // R4: pre-decrement address equals write-back value
  a_r4_predec: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_mode == AM_PREDEC |=> out_wb_en && out_wb_val == out_addr
      && out_addr == $past(in_ptr_val) - AW'(1));
  // R6: direct mode ignores the pointer
  a_r6_direct: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_mode == AM_DIRECT |=> out_addr == $past(in_direct) && !out_wb_en);
  // R9: port number tracks the I/O address
  a_r9_port: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sel_io |-> out_io_port == IO_W'(out_addr - AW'(NUM_REGS)));
  // R1: idle after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    $past(!rst_n) |-> !out_valid);
endmodule

// File: tb/ptr_addr_gen_test.sv
`timescale 1ns/1ps
module ptr_addr_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        in_valid = 0, out_ready = 0;
  logic [1:0]  in_ptr_sel = 0;
  logic [2:0]  in_mode = 0;
  logic [15:0] in_ptr_val = 0, in_direct = 0;
  logic [5:0]  in_disp = 0;
  logic        in_ready, out_valid, out_sel_reg, out_sel_io, out_sel_sram, out_sel_ext, out_prog, out_wb_en;
  logic [15:0] out_addr, out_wb_val;
  logic [5:0]  out_io_port;
  logic [1:0]  out_wb_ptr;

  ptr_addr_gen uut (.*);

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;

  // reference state
  bit m_valid = 0;
  int m_mode, m_sel, m_addr, m_wb_val;
  bit m_wb_en, m_prog;

  function automatic string tag_of(int mode);
    case (mode)
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  task automatic compare();
    int er, ei, es, ex, ep;
    chk("R10 out_valid", out_valid, m_valid);
    if (m_valid) begin
      chk(tag_of(m_mode), out_addr, m_addr);
      chk(tag_of(m_mode), out_wb_en, m_wb_en);
      chk("R7 prog", out_prog, m_prog);
      if (m_wb_en) begin
        chk(tag_of(m_mode), out_wb_val, m_wb_val);
        chk(tag_of(m_mode), out_wb_ptr, m_sel);
      end
      er = 0; ei = 0; es = 0; ex = 0; ep = 0;
      if (!m_prog) begin
        if (m_addr < 32) er = 1;
        else if (m_addr < 96) begin ei = 1; ep = m_addr - 32; end
        else if (m_addr < 352) es = 1;
        else ex = 1;
      end
      chk("R8 reg", out_sel_reg, er);
      chk("R8 io", out_sel_io, ei);
      chk("R8 sram", out_sel_sram, es);
      chk("R8 ext", out_sel_ext, ex);
      chk("R9 port", out_io_port, ep);
    end
  endtask

  // one cycle: compare, drive, check ready, advance model
  task automatic step(bit v, int sel, int mode, int p, int q, int d, bit ordy);
    @(negedge clk);
    cycles++;
    compare();
    in_valid = v; in_ptr_sel = 2'(sel); in_mode = 3'(mode);
    in_ptr_val = 16'(p); in_disp = 6'(q); in_direct = 16'(d); out_ready = ordy;
    #1;
    chk("R10 in_ready", in_ready, (!m_valid || ordy));
    if (m_valid && ordy) m_valid = 0;
    if (v && (!m_valid)) begin
      m_valid = 1; m_mode = mode; m_sel = sel;
      m_wb_en = 0; m_prog = 0; m_addr = p; m_wb_val = p;
      case (mode)
        1: begin m_wb_en = 1; m_wb_val = (p + 1) & 16'hFFFF; end
        2: begin m_addr = (p - 1) & 16'hFFFF; m_wb_en = 1; m_wb_val = m_addr; end
        3: if (sel == 1 || sel == 2) m_addr = (p + q) & 16'hFFFF;
        4: m_addr = d;
        5: m_prog = 1;
        default: ;
      endcase
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 out_valid", out_valid, 0);
    chk("R1 in_ready", in_ready, 1);
    // R3 wrap of post-increment
    step(1, 0, 1, 16'hFFFF, 0, 0, 1);
    // R4 wrap of pre-decrement
    step(1, 2, 2, 16'h0000, 0, 0, 1);
    // R5 Y with max q near top, wraps into I/O
    step(1, 1, 3, 16'hFFF0, 63, 0, 1);
    // R5 X ignores q
    step(1, 0, 3, 16'h0100, 63, 0, 1);
    // R5 Z with q
    step(1, 2, 3, 16'h0050, 17, 0, 1);
    // R6 direct at every region edge, pointer ignored
    step(1, 1, 4, 16'h1234, 5, 16'h001F, 1);
    step(1, 1, 4, 16'h1234, 5, 16'h0020, 1);
    step(1, 1, 4, 16'h1234, 5, 16'h005F, 1);
    step(1, 1, 4, 16'h1234, 5, 16'h0060, 1);
    step(1, 1, 4, 16'h1234, 5, 16'h015F, 1);
    step(1, 1, 4, 16'h1234, 5, 16'h0160, 1);
    // R7 lookup at an I/O-looking address
    step(1, 2, 5, 16'h0030, 0, 0, 1);
    // R2 plain and reserved codes
    step(1, 1, 0, 16'h0010, 9, 0, 1);
    step(1, 0, 6, 16'h0090, 9, 0, 1);
    step(1, 2, 7, 16'hABCD, 9, 0, 1);
    // R10 stall: hold two cycles with new requests offered
    step(1, 1, 1, 16'h0040, 0, 0, 0);
    step(1, 2, 2, 16'h7777, 0, 0, 0);
    step(1, 2, 2, 16'h7777, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1);
    // random traffic with random back-pressure
    for (int i = 0; i < 4000; i++) begin
      int p;
      p = ($urandom % 2) ? int'($urandom % 400) : int'($urandom & 16'hFFFF);
      if ($urandom % 8 == 0) p = ($urandom % 2) ? 16'hFFFF : 0;
      step(($urandom % 4) != 0, $urandom % 4, $urandom % 8, p,
           $urandom % 64, ($urandom % 2) ? int'($urandom % 400) : int'($urandom & 16'hFFFF),
           ($urandom % 3) != 0);
    end
    step(0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule